// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block caches virtual-to-physical page translations for a core that issues three kinds of access: instruction fetch, data load and data store. It is direct-mapped. Each entry holds one translation, kept as the physical-minus-virtual address difference. Each entry also has three independent tags, one per access kind. A lookup hits only when the tag for its own kind names the requested page. A core can therefore hold a page as readable without holding it as writable, until it refills the entry for that kind.

Pages are 4 KiB. A lookup is combinational: the hit flags and the physical address come back in the same cycle. A refill or a flush changes state at the next rising clock edge. A refill for one kind keeps the other kinds' tags if they name the same page and invalidates them if they name a different page. At any time, all valid tags of an entry therefore describe one page. A flush invalidates everything. Reset has the same effect as a flush.

Both the lookup and the refill port are qualified by a valid bit and are accepted in every cycle. The block never stalls, so neither port has a ready signal and there is no back-pressure. The flush input is a plain control pulse.

Top module: `xlat_cache`

## Requirements
- R1: From reset until the first refill, every lookup misses.
- R2: The entry index is the virtual page number (`va[ADDR_W-1:12]`) modulo `ENTRIES`. The tag holds the full page number, so a lookup to a different page that shares the index misses.
- R3: On a hit, `lk_pa` equals `lk_va + (rf_pa - rf_va)` modulo 2^ADDR_W, where `rf_pa` and `rf_va` come from the most recent accepted refill at that index.
- R4: A refill writes only the tag of its own access kind. The tags of the other kinds keep their state when they already name the same page.
- R5: A refill invalidates the tags of the other kinds at its index when they name a different page.
- R6: A flush invalidates all tags of all three kinds at the next edge. A flush wins over a refill in the same cycle, and that refill is dropped.
- R7: A lookup is combinational. A refill takes effect at the next edge, so a lookup in the same cycle as a refill sees the state from before the refill.
- R8: The kind encoding is 2'b00 fetch, 2'b01 load, 2'b10 store, and 2'b11 is treated as load. `lk_hit_vec` reports, for `lk_va`, the tag match of every kind: bit 0 fetch, bit 1 load, bit 2 store. `lk_hit` is the bit selected by `lk_kind`.
- R9: When `lk_valid` is low, `lk_hit` and `lk_hit_vec` are zero. On any miss, `lk_pa` is zero.
- R10: The top page (page number all ones) can be cached and hit. An invalidated tag never matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; invalidates all tags |
| lk_valid | input | 1 | Lookup request valid |
| lk_va | input | ADDR_W | Lookup virtual address |
| lk_kind | input | 2 | Lookup access kind |
| lk_hit | output | 1 | Hit for the lookup's own kind |
| lk_hit_vec | output | 3 | Tag match per kind (fetch, load, store) |
| lk_pa | output | ADDR_W | Translated physical address, zero on miss |
| rf_valid | input | 1 | Refill request valid |
| rf_va | input | ADDR_W | Refill virtual address |
| rf_pa | input | ADDR_W | Refill physical address |
| rf_kind | input | 2 | Refill access kind |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench targets these corner cases:

- **Aliasing pages.** Two pages share an index. A design that compared only the index bits would report a false hit with the wrong address.
- **Cross-kind refills.** A store refill lands on an entry that holds a different page for load and fetch. If the design failed to invalidate those tags, it would translate the old page through the new difference. If it invalidated tags that named the same page, it would turn valid load or fetch hits into misses.
- **Flush and refill together.** A design that let the refill win would hit after the flush.
- **Refill and lookup together.** A design that forwarded the refill would hit one cycle early.
- **The all-ones page and kind code 2'b11.** These catch a design that lets the invalidation pattern match a real page, or that decodes the spare code as a fourth kind.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // fixed 4 KiB pages
  localparam int PG_SHIFT = 12;
  localparam int N_KINDS  = 3;

  // access kind codes seen on the ports
  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_LOAD  = 2'b01,
    KIND_STORE = 2'b10,
    KIND_SPARE = 2'b11
  } acc_kind_e;

  // tag-bank slot per kind: 0 fetch, 1 load, 2 store; spare code behaves as load
  function automatic logic [1:0] kind_slot(input logic [1:0] kind);
    logic [1:0] slot;
    case (kind)
      KIND_FETCH: slot = 2'd0;
      KIND_STORE: slot = 2'd2;
      default:    slot = 2'd1;
    endcase
    return slot;
  endfunction

endpackage

// File: rtl/xlat_tag_bank.sv
module xlat_tag_bank #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int SLOT    = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             rf_valid,
  input  logic [1:0]       rf_slot,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_match
);
  localparam int         IDX_W   = $clog2(ENTRIES);
  localparam int         TAG_W   = VPN_W + 1;   // extra top bit keeps the invalid pattern unmatchable
  localparam logic [1:0] MY_SLOT = 2'(SLOT);

  logic [TAG_W-1:0] tag_q [ENTRIES];

  logic [IDX_W-1:0] rf_idx;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] rf_tag;
  logic [TAG_W-1:0] lk_tag;

  assign rf_idx = rf_vpn[IDX_W-1:0];
  assign lk_idx = lk_vpn[IDX_W-1:0];
  assign rf_tag = {1'b0, rf_vpn};
  assign lk_tag = {1'b0, lk_vpn};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '1;
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '1;
    end else if (rf_valid) begin
      if (rf_slot == MY_SLOT) begin
        tag_q[rf_idx] <= rf_tag;
      end else if (tag_q[rf_idx] != rf_tag) begin
        // another kind is filling this entry with a different page
        tag_q[rf_idx] <= '1;
      end
    end
  end

  assign lk_match = (tag_q[lk_idx] == lk_tag);

endmodule

// File: rtl/xlat_delta_store.sv
module xlat_delta_store #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [ADDR_W-1:0]          wr_delta,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output logic [ADDR_W-1:0]          rd_delta
);
  logic [ADDR_W-1:0] delta_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) delta_q[i] <= '0;
    end else if (wr_en) begin
      delta_q[wr_idx] <= wr_delta;
    end
  end

  assign rd_delta = delta_q[rd_idx];

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_va,
  input  logic [1:0]        lk_kind,
  output logic              lk_hit,
  output logic [2:0]        lk_hit_vec,
  output logic [ADDR_W-1:0] lk_pa,
  input  logic              rf_valid,
  input  logic [ADDR_W-1:0] rf_va,
  input  logic [ADDR_W-1:0] rf_pa,
  input  logic [1:0]        rf_kind,
  input  logic              flush
);
  import xlat_pkg::*;

  localparam int VPN_W = ADDR_W - PG_SHIFT;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0]   lk_vpn;
  logic [VPN_W-1:0]   rf_vpn;
  logic [1:0]         lk_slot;
  logic [1:0]         rf_slot;
  logic [N_KINDS-1:0] match;
  logic [ADDR_W-1:0]  rd_delta;

  assign lk_vpn  = lk_va[ADDR_W-1:PG_SHIFT];
  assign rf_vpn  = rf_va[ADDR_W-1:PG_SHIFT];
  assign lk_slot = kind_slot(lk_kind);
  assign rf_slot = kind_slot(rf_kind);

  // one tag bank per access kind
  for (genvar g = 0; g < N_KINDS; g++) begin : g_bank
    xlat_tag_bank #(
      .ENTRIES(ENTRIES),
      .VPN_W  (VPN_W),
      .SLOT   (g)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .rf_valid(rf_valid),
      .rf_slot (rf_slot),
      .rf_vpn  (rf_vpn),
      .lk_vpn  (lk_vpn),
      .lk_match(match[g])
    );
  end

  // shared translation difference, dropped when a flush wins
  xlat_delta_store #(
    .ENTRIES(ENTRIES),
    .ADDR_W (ADDR_W)
  ) u_delta (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rf_valid && !flush),
    .wr_idx  (rf_vpn[IDX_W-1:0]),
    .wr_delta(rf_pa - rf_va),
    .rd_idx  (lk_vpn[IDX_W-1:0]),
    .rd_delta(rd_delta)
  );

  assign lk_hit_vec = lk_valid ? match : 3'b000;

  always_comb begin
    case (lk_slot)
      2'd0:    lk_hit = lk_hit_vec[0];
      2'd1:    lk_hit = lk_hit_vec[1];
      default: lk_hit = lk_hit_vec[2];
    endcase
  end

  assign lk_pa = lk_hit ? (lk_va + rd_delta) : '0;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_va,
  input logic [1:0]        lk_kind,
  input logic              lk_hit,
  input logic [2:0]        lk_hit_vec,
  input logic [ADDR_W-1:0] lk_pa,
  input logic              rf_valid,
  input logic [ADDR_W-1:0] rf_va,
  input logic [ADDR_W-1:0] rf_pa,
  input logic [1:0]        rf_kind,
  input logic              flush
);
  import xlat_pkg::*;

  localparam int VPN_W = ADDR_W - PG_SHIFT;

  logic              seen_fill;
  logic              fill_ok;
  logic [1:0]        rf_slot_c;
  logic [1:0]        lk_slot_c;
  logic [ADDR_W-1:0] rf_diff_c;
  logic [VPN_W-1:0]  rf_page_c;
  logic [VPN_W-1:0]  lk_page_c;

  assign fill_ok   = rf_valid && !flush;
  assign rf_slot_c = kind_slot(rf_kind);
  assign lk_slot_c = kind_slot(lk_kind);
  assign rf_diff_c = rf_pa - rf_va;
  assign rf_page_c = rf_va[ADDR_W-1:PG_SHIFT];
  assign lk_page_c = lk_va[ADDR_W-1:PG_SHIFT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_fill <= 1'b0;
    else if (fill_ok) seen_fill <= 1'b1;
  end

  // R1: nothing hits before the first accepted refill
  p_cold_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_fill |-> !lk_hit);

  // R4: a page just refilled for a kind hits for that kind
  p_fill_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_ok) && lk_valid && lk_page_c == $past(rf_page_c)
     && lk_slot_c == $past(rf_slot_c)) |-> lk_hit);

  // R3: that hit translates through the refill's difference
  p_fill_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_ok) && lk_valid && lk_page_c == $past(rf_page_c)
     && lk_slot_c == $past(rf_slot_c)) |-> lk_pa == lk_va + $past(rf_diff_c));

  // R6: the cycle after a flush, no kind matches
  p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> lk_hit_vec == 3'b000);

  // R8: the selected hit is one of the reported per-kind matches
  p_hit_in_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_hit_vec != 3'b000);

  // R9: an idle lookup port reports nothing
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (lk_hit_vec == 3'b000 && !lk_hit && lk_pa == '0));

endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
  localparam int ENTRIES = 16;
  localparam int AW      = 32;
  localparam int IW      = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_va = '0;
  logic [1:0]    lk_kind = 2'b00;
  logic          lk_hit;
  logic [2:0]    lk_hit_vec;
  logic [AW-1:0] lk_pa;
  logic          rf_valid = 1'b0;
  logic [AW-1:0] rf_va = '0;
  logic [AW-1:0] rf_pa = '0;
  logic [1:0]    rf_kind = 2'b00;
  logic          flush = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  xlat_cache #(.ENTRIES(ENTRIES), .ADDR_W(AW)) i_xlat_cache (.*);

  typedef struct {
    logic          hit;
    logic [2:0]    vec;
    logic [AW-1:0] pa;
    string         req;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  // reference model: one tag per kind (bit 20 set means invalid), one difference per entry
  logic [20:0]   m_tag [3][ENTRIES];
  logic [AW-1:0] m_diff [ENTRIES];

  function automatic int slot_of(input logic [1:0] k);
    if (k == 2'b00) return 0;
    if (k == 2'b10) return 2;
    return 1;  // load and the spare code
  endfunction

  task automatic model_flush();
    for (int t = 0; t < 3; t++)
      for (int e = 0; e < ENTRIES; e++) m_tag[t][e] = '1;
  endtask

  // one cycle: drive, predict the lookup from pre-edge state, then advance the model
  task automatic step(input logic lv, input logic [AW-1:0] lva, input logic [1:0] lk,
                      input logic rv, input logic [AW-1:0] rva, input logic [AW-1:0] rpa,
                      input logic [1:0] rk, input logic fl, input string req);
    exp_t e;
    int   li;
    int   ri;
    @(posedge clk);
    #1;
    lk_valid = lv; lk_va = lva; lk_kind = lk;
    rf_valid = rv; rf_va = rva; rf_pa = rpa; rf_kind = rk;
    flush = fl;
    li = int'(lva[12 +: IW]);
    for (int t = 0; t < 3; t++)
      e.vec[t] = lv && (m_tag[t][li] == {1'b0, lva[AW-1:12]});
    e.hit = e.vec[slot_of(lk)];
    e.pa  = e.hit ? lva + m_diff[li] : '0;
    e.req = req;
    sb_q.push_back(e);
    if (fl) begin
      model_flush();
    end else if (rv) begin
      ri = int'(rva[12 +: IW]);
      for (int t = 0; t < 3; t++) begin
        if (t == slot_of(rk)) m_tag[t][ri] = {1'b0, rva[AW-1:12]};
        else if (m_tag[t][ri] != {1'b0, rva[AW-1:12]}) m_tag[t][ri] = '1;
      end
      m_diff[ri] = rpa - rva;
    end
  endtask

  task automatic look(input logic [AW-1:0] va, input logic [1:0] k, input string req);
    step(1'b1, va, k, 1'b0, '0, '0, 2'b00, 1'b0, req);
  endtask

  task automatic fill(input logic [AW-1:0] va, input logic [AW-1:0] pa, input logic [1:0] k,
                      input string req);
    step(1'b0, '0, 2'b00, 1'b1, va, pa, k, 1'b0, req);
  endtask

  // monitor: compares combinational results away from the edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (lk_hit !== e.hit || lk_hit_vec !== e.vec || lk_pa !== e.pa) begin
        n_fail++;
        $display("FAIL %s: hit=%0b vec=%b pa=%h expected hit=%0b vec=%b pa=%h",
                 e.req, lk_hit, lk_hit_vec, lk_pa, e.hit, e.vec, e.pa);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  localparam logic [AW-1:0] VA_A = 32'h0000_3123;
  localparam logic [AW-1:0] VA_B = 32'h0001_3040;  // aliases VA_A's index
  localparam logic [AW-1:0] VA_C = 32'h0000_7000;
  localparam logic [AW-1:0] VA_T = 32'hFFFF_F800;  // top page

  initial begin
    model_flush();
    for (int e = 0; e < ENTRIES; e++) m_diff[e] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 cold misses of every kind
    look(VA_A, 2'b01, "R1");
    look(VA_A, 2'b00, "R1");
    look(32'h1234_5000, 2'b10, "R1");

    // R7 refill and lookup of the same page in one cycle
    step(1'b1, VA_A, 2'b01, 1'b1, VA_A, 32'h8765_4123, 2'b01, 1'b0, "R7");
    look(32'h0000_3FF0, 2'b01, "R3");
    look(VA_A, 2'b00, "R4");

    // R4 same-page refill of another kind keeps the load tag
    fill(VA_A, 32'h4000_0123, 2'b00, "R4");
    look(VA_A, 2'b01, "R4");
    look(VA_A, 2'b00, "R4");

    // R5 / R2 aliasing store refill
    fill(VA_B, 32'h0BAD_0040, 2'b10, "R5");
    look(VA_A, 2'b01, "R5");
    look(VA_A, 2'b00, "R5");
    look(VA_B, 2'b10, "R2");
    look(VA_A, 2'b10, "R2");

    // R9 idle port and miss address
    step(1'b0, VA_B, 2'b10, 1'b0, '0, '0, 2'b00, 1'b0, "R9");
    look(VA_B, 2'b01, "R9");

    // R8 spare kind code behaves as load
    fill(VA_A, 32'h2222_0123, 2'b11, "R8");
    look(VA_A, 2'b01, "R8");
    look(VA_A, 2'b11, "R8");
    look(VA_A, 2'b10, "R8");

    // R6 flush beats a simultaneous refill
    step(1'b0, '0, 2'b00, 1'b1, VA_C, 32'h0000_9000, 2'b00, 1'b1, "R6");
    look(VA_C, 2'b00, "R6");
    look(VA_A, 2'b01, "R6");

    // R10 top page caches; flush pattern never matches it afterwards
    fill(VA_T, 32'h0000_1800, 2'b10, "R10");
    look(32'hFFFF_FFFC, 2'b10, "R10");
    step(1'b0, '0, 2'b00, 1'b0, '0, '0, 2'b00, 1'b1, "R10");
    look(32'hFFFF_FFFC, 2'b10, "R10");

    // R2 randomized traffic over a small, aliasing page pool
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      logic [AW-1:0] b;
      logic [19:0]   vp;
      logic [19:0]   vr;
      vp = 20'(($urandom_range(0, 3) << 4) | $urandom_range(0, 3));
      vr = 20'(($urandom_range(0, 3) << 4) | $urandom_range(0, 3));
      if ($urandom_range(0, 40) == 0) vp = 20'hFFFFF;
      if ($urandom_range(0, 40) == 0) vr = 20'hFFFFF;
      a = {vp, 12'($urandom)};
      b = {vr, 12'($urandom)};
      step(1'($urandom_range(0, 5) != 0), a, 2'($urandom),
           1'($urandom_range(0, 2) == 0), b, $urandom, 2'($urandom),
           1'($urandom_range(0, 60) == 0), "R2");
    end

    step(1'b0, '0, 2'b00, 1'b0, '0, '0, 2'b00, 1'b0, "R9");
    @(negedge clk);
    #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule